// File: doc/BRIEF.md
# Shared Office Call Bell with Reminder

This block serves a set of desk stations that summon one attendant. Each station has an active-low push button. Pressing it records a pending call for that station and turns on the station's lamp. The record stays after the button is let go, so the attendant can see who called. A single shared bell is on only while someone is physically holding a button down. It does not track the stored calls.

While at least one call is still pending, a reminder sequencer repeats a slow cadence: a long silent stretch, then a short burst of square-wave tone. A clear-all input erases every pending call at once. A per-station clear input erases one call only. When no call is left, the reminder stops.

The block runs from a slow clock tick. The silent length, the burst length and the tone half-period are parameters counted in ticks. Button inputs are brought into the clock domain by two flip-flops each. Debounce and the drive circuits for the lamps, bell and speaker sit outside this block.

Top module: `call_bell_top`

## Requirements
- R1: While reset is held and right after it is released, every lamp is off, the bell is off and the beeper is low.
- R2: Bit i of `callBtnN` going low sets lamp i. The lamp is observed on the third clock edge after the input changes. It stays on after the button is released, until that station is cleared.
- R3: `bellOn` is high exactly when at least one bit of `callBtnN` was low two clock edges earlier. Pending calls have no effect on it.
- R4: A low `clearAllN` at a clock edge turns every lamp off at that edge.
- R5: A low `clearStnN[i]` at a clock edge turns lamp i off at that edge and leaves every other lamp unchanged.
- R6: When a station's clear and its pressed button meet at the same edge, the clear wins and the lamp stays off.
- R7: The beeper stays low whenever no lamp is on, from the clock edge after the last lamp goes off.
- R8: The reminder becomes active on the edge after the first lamp lights (edge E). Silent phases last QUIET_CYCLES edges and tone bursts last TONE_CYCLES edges, alternating and starting with silence. Burst n therefore starts at edge E + QUIET_CYCLES + n*(QUIET_CYCLES+TONE_CYCLES).
- R9: Within a burst the beeper starts low and toggles every HALF_CYCLES edges. It rises at burst offsets HALF_CYCLES*(2m+1) that fall below TONE_CYCLES. It is low throughout every silent phase.
- R10: Each time the reminder becomes active again after all calls were cleared, the cadence restarts from the beginning of a silent phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock tick |
| rstN | input | 1 | Asynchronous active-low reset |
| callBtnN | input | NUM_STATIONS | Station push buttons, active low, bit i is station i |
| clearAllN | input | 1 | Synchronous active-low clear of every pending call |
| clearStnN | input | NUM_STATIONS | Synchronous active-low clear of one station's call |
| callLamp | output | NUM_STATIONS | Pending-call lamps, bit i is station i |
| bellOn | output | 1 | Shared bell enable, follows live button state |
| beepTone | output | 1 | Reminder tone waveform |

## Verification
The bench builds the block with four stations, QUIET_CYCLES=20, TONE_CYCLES=8 and HALF_CYCLES=2. With these values several complete silent/burst periods of 28 edges fit into a short run. Every expected rising edge of the tone can be predicted to the exact tick, including two rises per burst. Such short windows also let a clear land inside a silent phase between bursts. This shows both that the reminder stops and that the next call restarts the cadence from silence.

// File: rtl/bell_pkg.sv
`timescale 1ns/1ps
package bell_pkg;
  typedef enum logic [1:0] {
    REM_IDLE  = 2'd0,
    REM_QUIET = 2'd1,
    REM_TONE  = 2'd2
  } remState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic phaseClr;  // restart the phase counter
    logic toneWin;   // current phase is a tone burst
  } bellStrobe_t;
endpackage

// File: rtl/bell_datapath.sv
`timescale 1ns/1ps
module bell_datapath
  import bell_pkg::*;
#(
  parameter int NUM_STATIONS = 4,
  parameter int QUIET_CYCLES = 5000,
  parameter int TONE_CYCLES  = 1000,
  parameter int HALF_CYCLES  = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_STATIONS-1:0] callBtnN,
  input  logic                    clearAllN,
  input  logic [NUM_STATIONS-1:0] clearStnN,
  input  bellStrobe_t             strobe,
  output logic [NUM_STATIONS-1:0] callLamp,
  output logic                    bellOn,
  output logic                    anyPending,
  output logic                    phaseDone,
  output logic                    beepTone
);
  localparam int MAX_PHASE = (QUIET_CYCLES > TONE_CYCLES) ? QUIET_CYCLES : TONE_CYCLES;
  localparam int PH_W      = $clog2(MAX_PHASE + 1);
  localparam int HALF_W    = $clog2(HALF_CYCLES + 1);
  localparam logic [PH_W-1:0]   QUIET_LAST = PH_W'(QUIET_CYCLES - 1);
  localparam logic [PH_W-1:0]   TONE_LAST  = PH_W'(TONE_CYCLES - 1);
  localparam logic [HALF_W-1:0] HALF_LAST  = HALF_W'(HALF_CYCLES - 1);

  logic [NUM_STATIONS-1:0] syncA;
  logic [NUM_STATIONS-1:0] syncB;
  logic [NUM_STATIONS-1:0] pressed;
  logic [NUM_STATIONS-1:0] pending;

  // two-stage synchronizer, idle level is released (high)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '1;
      syncB <= '1;
    end else begin
      syncA <= callBtnN;
      syncB <= syncA;
    end
  end

  assign pressed = ~syncB;
  assign bellOn  = |pressed;

  // one call latch per station; clear beats set
  for (genvar st = 0; st < NUM_STATIONS; st++) begin : gStation
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pending[st] <= 1'b0;
      end else if (!clearAllN || !clearStnN[st]) begin
        pending[st] <= 1'b0;
      end else if (pressed[st]) begin
        pending[st] <= 1'b1;
      end
    end
  end

  assign callLamp   = pending;
  assign anyPending = |pending;

  // phase counter shared by silent and tone phases
  logic [PH_W-1:0] phaseCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strobe.phaseClr) begin
      phaseCnt <= '0;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  assign phaseDone = (phaseCnt == (strobe.toneWin ? TONE_LAST : QUIET_LAST));

  // tone divider, held at zero outside a burst
  logic [HALF_W-1:0] halfCnt;
  logic              toneLvl;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
      toneLvl <= 1'b0;
    end else if (!strobe.toneWin) begin
      halfCnt <= '0;
      toneLvl <= 1'b0;
    end else if (halfCnt == HALF_LAST) begin
      halfCnt <= '0;
      toneLvl <= ~toneLvl;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  assign beepTone = toneLvl & strobe.toneWin;
endmodule

// File: rtl/bell_control.sv
`timescale 1ns/1ps
module bell_control
  import bell_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyPending,
  input  logic        phaseDone,
  output bellStrobe_t strobe
);
  remState_t state;
  remState_t stateNext;

  always_comb begin
    stateNext       = state;
    strobe.phaseClr = 1'b0;
    strobe.toneWin  = 1'b0;
    unique case (state)
      REM_IDLE: begin
        strobe.phaseClr = 1'b1;
        if (anyPending) stateNext = REM_QUIET;
      end
      REM_QUIET: begin
        if (!anyPending) begin
          stateNext = REM_IDLE;
        end else if (phaseDone) begin
          stateNext       = REM_TONE;
          strobe.phaseClr = 1'b1;
        end
      end
      REM_TONE: begin
        strobe.toneWin = 1'b1;
        if (!anyPending) begin
          stateNext = REM_IDLE;
        end else if (phaseDone) begin
          stateNext       = REM_QUIET;
          strobe.phaseClr = 1'b1;
        end
      end
      default: stateNext = REM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= REM_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/call_bell_top.sv
`timescale 1ns/1ps
module call_bell_top
  import bell_pkg::*;
#(
  parameter int NUM_STATIONS = 4,
  parameter int QUIET_CYCLES = 5000,
  parameter int TONE_CYCLES  = 1000,
  parameter int HALF_CYCLES  = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_STATIONS-1:0] callBtnN,
  input  logic                    clearAllN,
  input  logic [NUM_STATIONS-1:0] clearStnN,
  output logic [NUM_STATIONS-1:0] callLamp,
  output logic                    bellOn,
  output logic                    beepTone
);
  bellStrobe_t strobe;
  logic        anyPending;
  logic        phaseDone;

  bell_control uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .anyPending (anyPending),
    .phaseDone  (phaseDone),
    .strobe     (strobe)
  );

  bell_datapath #(
    .NUM_STATIONS (NUM_STATIONS),
    .QUIET_CYCLES (QUIET_CYCLES),
    .TONE_CYCLES  (TONE_CYCLES),
    .HALF_CYCLES  (HALF_CYCLES)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .callBtnN   (callBtnN),
    .clearAllN  (clearAllN),
    .clearStnN  (clearStnN),
    .strobe     (strobe),
    .callLamp   (callLamp),
    .bellOn     (bellOn),
    .anyPending (anyPending),
    .phaseDone  (phaseDone),
    .beepTone   (beepTone)
  );
endmodule

// File: rtl/bell_checker.sv
`timescale 1ns/1ps
module bell_checker #(
  parameter int NUM_STATIONS = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [NUM_STATIONS-1:0] callBtnN,
  input logic                    clearAllN,
  input logic [NUM_STATIONS-1:0] clearStnN,
  input logic [NUM_STATIONS-1:0] callLamp,
  input logic                    bellOn,
  input logic                    beepTone
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  assert_bell_live_R3: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3) |-> (bellOn == |(~$past(callBtnN, 2))));

  assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rstN)
    !clearAllN |=> (callLamp == '0));

  assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((callLamp == '0) && ($past(callLamp) == '0)) |-> !beepTone);

  for (genvar st = 0; st < NUM_STATIONS; st++) begin : gStn
    assert_station_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
      !clearStnN[st] |=> !callLamp[st]);

    assert_lamp_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
      (callLamp[st] && clearAllN && clearStnN[st]) |=> callLamp[st]);
  end
endmodule

bind call_bell_top bell_checker #(.NUM_STATIONS(NUM_STATIONS)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .callBtnN  (callBtnN),
  .clearAllN (clearAllN),
  .clearStnN (clearStnN),
  .callLamp  (callLamp),
  .bellOn    (bellOn),
  .beepTone  (beepTone)
);

// File: tb/sim_call_bell_top.sv
`timescale 1ns/1ps
module sim_call_bell_top;
  localparam int NS = 4;
  localparam int QC = 20;
  localparam int TC = 8;
  localparam int HC = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] callBtnN = '1;
  logic          clearAllN = 1'b1;
  logic [NS-1:0] clearStnN = '1;
  logic [NS-1:0] callLamp;
  logic          bellOn;
  logic          beepTone;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int expQ[$];
  bit prevBeep = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  call_bell_top #(
    .NUM_STATIONS (NS),
    .QUIET_CYCLES (QC),
    .TONE_CYCLES  (TC),
    .HALF_CYCLES  (HC)
  ) u0 (
    .clk       (clk),
    .rstN      (rstN),
    .callBtnN  (callBtnN),
    .clearAllN (clearAllN),
    .clearStnN (clearStnN),
    .callLamp  (callLamp),
    .bellOn    (bellOn),
    .beepTone  (beepTone)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  task automatic waitTo(int target);
    while (cyc < target) @(negedge clk);
  endtask

  // driver side: expected tone rises for a number of bursts after a press at edge p
  task automatic pushBursts(int p, int bursts);
    for (int b = 0; b < bursts; b++) begin
      for (int off = HC; off < TC; off += 2 * HC) begin
        expQ.push_back(p + 3 + QC + b * (QC + TC) + off);
      end
    end
  endtask

  // monitor: pop and compare each observed rising edge of the tone
  always @(negedge clk) begin
    if (rstN) begin
      if (beepTone && !prevBeep) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7/R8 unexpected tone rise", cyc, -1);
        end else begin
          int e;
          e = expQ.pop_front();
          check(cyc == e, "R8/R9/R10 tone rise time", cyc, e);
        end
      end
      prevBeep = beepTone;
    end
  end

  initial begin
    #(100000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int p;
    int base;
    repeat (3) @(negedge clk);
    check(callLamp == '0 && !bellOn && !beepTone, "R1 in reset", int'(callLamp), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(callLamp == '0 && !bellOn && !beepTone, "R1 after reset", int'(callLamp), 0);

    // station 2 press: latch, bell, two bursts, then clear-all in a silent phase
    p = cyc + 1;
    callBtnN[2] = 1'b0;
    pushBursts(p, 2);
    @(negedge clk);
    check(!bellOn, "R3 bell delayed by sync", bellOn, 0);
    @(negedge clk);
    check(bellOn, "R3 bell on while held", bellOn, 1);
    check(callLamp == '0, "R2 lamp not yet", int'(callLamp), 0);
    @(negedge clk);
    check(callLamp == 4'b0100, "R2 lamp on", int'(callLamp), 4);
    repeat (3) @(negedge clk);
    callBtnN[2] = 1'b1;
    repeat (2) @(negedge clk);
    check(!bellOn, "R3 bell off after release", bellOn, 0);
    check(callLamp == 4'b0100, "R2 lamp held after release", int'(callLamp), 4);
    base = p + 3 + QC;
    waitTo(base + QC + 2 * TC + 1);
    clearAllN = 1'b0;
    @(negedge clk);
    clearAllN = 1'b1;
    check(callLamp == '0, "R4 clear all", int'(callLamp), 0);
    repeat (2 * (QC + TC)) @(negedge clk);
    check(!beepTone, "R7 silent with no call", beepTone, 0);
    check(expQ.size() == 0, "R8 all bursts seen", expQ.size(), 0);

    // stations 0 and 3: cadence restarts from silence; per-station clears
    p = cyc + 1;
    callBtnN[0] = 1'b0;
    callBtnN[3] = 1'b0;
    pushBursts(p, 2);
    repeat (3) @(negedge clk);
    callBtnN[0] = 1'b1;
    callBtnN[3] = 1'b1;
    check(callLamp == 4'b1001, "R2 two lamps", int'(callLamp), 9);
    base = p + 3 + QC;
    waitTo(base + TC + 1);
    clearStnN[0] = 1'b0;
    @(negedge clk);
    clearStnN[0] = 1'b1;
    check(callLamp == 4'b1000, "R5 only station 0 cleared", int'(callLamp), 8);
    waitTo(base + QC + 2 * TC + 1);
    check(expQ.size() == 0, "R10 restart bursts seen", expQ.size(), 0);
    clearStnN[3] = 1'b0;
    @(negedge clk);
    clearStnN[3] = 1'b1;
    check(callLamp == '0, "R5 station 3 cleared", int'(callLamp), 0);

    // clear held while button held: clear wins, bell still follows button
    clearStnN[1] = 1'b0;
    callBtnN[1] = 1'b0;
    repeat (5) @(negedge clk);
    check(bellOn, "R3 bell ignores latch", bellOn, 1);
    check(callLamp == '0, "R6 clear beats press", int'(callLamp), 0);
    callBtnN[1] = 1'b1;
    repeat (3) @(negedge clk);
    clearStnN[1] = 1'b1;
    repeat (QC + TC + 4) @(negedge clk);
    check(callLamp == '0, "R6 lamp stays off", int'(callLamp), 0);
    check(!beepTone, "R7 no tone after blocked press", beepTone, 0);

    // overlapping buttons, cleared before the silent phase ends
    callBtnN[0] = 1'b0;
    repeat (2) @(negedge clk);
    callBtnN[1] = 1'b0;
    repeat (2) @(negedge clk);
    callBtnN[0] = 1'b1;
    repeat (2) @(negedge clk);
    check(bellOn, "R3 bell held by station 1", bellOn, 1);
    callBtnN[1] = 1'b1;
    repeat (2) @(negedge clk);
    check(!bellOn, "R3 bell off with none held", bellOn, 0);
    check(callLamp == 4'b0011, "R2 overlapping lamps", int'(callLamp), 3);
    clearAllN = 1'b0;
    @(negedge clk);
    clearAllN = 1'b1;
    check(callLamp == '0, "R4 clear all two lamps", int'(callLamp), 0);
    repeat (2 * (QC + TC)) @(negedge clk);
    check(expQ.size() == 0, "R8 no pending expectations", expQ.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule